// File: doc/BRIEF.md
# Shared-Pin Port and Address/Data Bus Pad Controller

This block drives the pads of two 8-bit bidirectional ports whose pins also carry a 16-bit multiplexed address/data bus. Software reaches four byte registers through a plain read/write strobe interface: one output-data register per port and one pin-input view per port. The pin-input view always shows the live pad level. When the port is idle, each pin drives the stored output byte. The drive style is either push-pull or open-drain, and it is chosen for a whole port at once.

A bus engine outside this block signals an external cycle with `bus_active`. While that signal is high, the bus engine owns every pin. With `bus_drive_en` high, it pushes its address/data word out in push-pull form. With `bus_drive_en` low, it releases the pins so that read data can come in. When the cycle ends, the stored software bytes come back onto the pins with no software action. A strap input gives the bus permanent ownership of the pins, so software data never reaches them.

The low port carries bus bits 7:0 and the high port carries bits 15:8. The drive mode of each port is taken from a request input and registered. After reset, both ports are open-drain.

Top module: `muxbus_port_ctrl`

## Requirements
- R1: After reset, both output-data registers read 8'hFF and both ports are open-drain, so all `pad_oe` bits are 0 while the bus is idle.
- R2: A write to address 16'h1FFC stores the low port byte and a write to 16'h1FFD stores the high port byte; reads of the same addresses return the stored byte in the same cycle `reg_rd` is high.
- R3: A read of 16'h1FFE returns `pad_in[7:0]` and a read of 16'h1FFF returns `pad_in[15:8]`, whatever the owner or drive mode.
- R4: With `bus_active` and `bus_drive_en` both high, `pad_oe` is all ones and `pad_out` equals `bus_ad_out`, with bits 7:0 on the low port and bits 15:8 on the high port.
- R5: With `bus_active` high and `bus_drive_en` low, `pad_oe` is all zeros and `bus_rd_data` equals `pad_in`.
- R6: In the cycle after `bus_active` falls, with the strap inactive, the pins drive the stored output bytes again.
- R7: A register write made during a bus cycle is stored but does not reach the pins until the bus releases them.
- R8: While `ext_strap` is 1, software data never reaches the pins: `pad_oe` is 1 only when `bus_active` and `bus_drive_en` are both high.
- R9: A port whose bit of `drv_pp_req` is 1 becomes push-pull one clock edge later: every pin of that port has `pad_oe`=1 and drives its stored bit.
- R10: In an open-drain port (request bit 0), a stored 0 gives `pad_oe`=1 with `pad_out`=0, and a stored 1 gives `pad_oe`=0.
- R11: Drive mode applies to whole ports, and each port follows its own request bit regardless of the other port's.
- R12: Writes to any address other than 16'h1FFC and 16'h1FFD change no register and no pin, and reads outside 16'h1FFC..16'h1FFF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| drv_pp_req | input | 2 | Per-port drive request, 1 = push-pull, 0 = open-drain |
| ext_strap | input | 1 | Locks the pins to bus use |
| bus_active | input | 1 | External bus cycle in progress |
| bus_drive_en | input | 1 | Bus engine sends address/data |
| bus_ad_out | input | 16 | Outgoing address/data word |
| bus_rd_data | output | 16 | Incoming pad levels for the bus engine |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |

## Verification
The bench sets up several handover cases. In one, a byte is written while the bus holds the pins. A design that skipped the store would lose the byte, and one that bypassed ownership would show it on the pins too early. The bench also checks that the stored byte returns on the first idle cycle, so a design that forgot the restore would leave the pins released. The strap is exercised with a write made while it is set, to catch software data leaking onto the pins. Mixed per-port modes and open-drain patterns catch any mode or polarity applied to the wrong port. Writes to pin-input and unmapped addresses catch loose address decoding.

// File: rtl/muxbus_port_pkg.sv
package muxbus_port_pkg;
   typedef enum logic {
      DRV_OPEN_DRAIN = 1'b0,
      DRV_PUSH_PULL  = 1'b1
   } drv_mode_e;

   // Owner of a port's pins in a given cycle
   typedef enum logic [1:0] {
      OWN_SOFTWARE = 2'd0,
      OWN_BUS_SEND = 2'd1,
      OWN_BUS_RECV = 2'd2
   } pin_owner_e;

   function automatic pin_owner_e owner_of(input logic active, input logic strap,
                                           input logic drive);
      if (active && drive) return OWN_BUS_SEND;
      if (active || strap) return OWN_BUS_RECV;
      return OWN_SOFTWARE;
   endfunction
endpackage

// File: rtl/mbp_out_regs.sv
module mbp_out_regs #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int OUT_BASE  = 'h1FFC,
   localparam int BUS_W    = PORT_W * NUM_PORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] wdata,
   output logic [BUS_W-1:0]  data_q
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(OUT_BASE + p));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   data_q[p*PORT_W +: PORT_W] <= '1;
         else if (hit) data_q[p*PORT_W +: PORT_W] <= wdata;
      end
   end
endmodule

// File: rtl/mbp_mode_regs.sv
module mbp_mode_regs #(
   parameter int NUM_PORTS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req,
   output logic [NUM_PORTS-1:0] pp_q
);
   import muxbus_port_pkg::*;
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pp_q[p] <= DRV_OPEN_DRAIN;
         else        pp_q[p] <= req[p];
      end
   end
endmodule

// File: rtl/mbp_pad_mux.sv
module mbp_pad_mux #(
   parameter int PORT_W         = 8,
   parameter bit HAS_OPEN_DRAIN = 1'b1
) (
   input  logic [PORT_W-1:0] sw_data,
   input  logic              pp_mode,
   input  logic              bus_active,
   input  logic              bus_drive,
   input  logic              strap,
   input  logic [PORT_W-1:0] bus_word,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe
);
   import muxbus_port_pkg::*;
   pin_owner_e owner;
   logic [PORT_W-1:0] sw_out, sw_oe;

   assign owner = owner_of(bus_active, strap, bus_drive);

   if (HAS_OPEN_DRAIN) begin : g_od
      always_comb begin
         if (pp_mode == DRV_PUSH_PULL) begin
            sw_out = sw_data;
            sw_oe  = '1;
         end else begin
            sw_out = '0;
            sw_oe  = ~sw_data;
         end
      end
   end else begin : g_pp
      logic unused_mode;
      assign unused_mode = pp_mode;
      assign sw_out = sw_data;
      assign sw_oe  = '1;
   end

   always_comb begin
      unique case (owner)
         OWN_BUS_SEND: begin pad_out = bus_word; pad_oe = '1;    end
         OWN_BUS_RECV: begin pad_out = '0;       pad_oe = '0;    end
         default:      begin pad_out = sw_out;   pad_oe = sw_oe; end
      endcase
   end
endmodule

// File: rtl/mbp_read_mux.sv
module mbp_read_mux #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int OUT_BASE  = 'h1FFC,
   localparam int BUS_W    = PORT_W * NUM_PORTS,
   localparam int PIN_BASE = OUT_BASE + NUM_PORTS
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  out_q,
   input  logic [BUS_W-1:0]  pins,
   output logic [PORT_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(OUT_BASE + p)) rdata = out_q[p*PORT_W +: PORT_W];
            if (addr == ADDR_W'(PIN_BASE + p)) rdata = pins[p*PORT_W +: PORT_W];
         end
      end
   end
endmodule

// File: rtl/muxbus_port_ctrl.sv
module muxbus_port_ctrl #(
   parameter int PORT_W         = 8,
   parameter int NUM_PORTS      = 2,
   parameter int ADDR_W         = 16,
   parameter int OUT_BASE       = 'h1FFC,
   parameter bit HAS_OPEN_DRAIN = 1'b1,
   localparam int BUS_W         = PORT_W * NUM_PORTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [PORT_W-1:0]    reg_wdata,
   output logic [PORT_W-1:0]    reg_rdata,
   input  logic [NUM_PORTS-1:0] drv_pp_req,
   input  logic                 ext_strap,
   input  logic                 bus_active,
   input  logic                 bus_drive_en,
   input  logic [BUS_W-1:0]     bus_ad_out,
   output logic [BUS_W-1:0]     bus_rd_data,
   input  logic [BUS_W-1:0]     pad_in,
   output logic [BUS_W-1:0]     pad_out,
   output logic [BUS_W-1:0]     pad_oe
);
   if (PORT_W < 1 || NUM_PORTS < 1) begin : g_bad_size
      $error("muxbus_port_ctrl: PORT_W and NUM_PORTS must be positive");
   end
   if (OUT_BASE < 0 || OUT_BASE + 2 * NUM_PORTS > (1 << ADDR_W)) begin : g_bad_map
      $error("muxbus_port_ctrl: register map does not fit ADDR_W");
   end

   logic [BUS_W-1:0]     out_q;
   logic [NUM_PORTS-1:0] pp_q;

   mbp_out_regs #(
      .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
   ) i_out_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .data_q(out_q)
   );

   mbp_mode_regs #(.NUM_PORTS(NUM_PORTS)) i_mode_regs (
      .clk(clk), .rst_n(rst_n), .req(drv_pp_req), .pp_q(pp_q)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pad
      mbp_pad_mux #(.PORT_W(PORT_W), .HAS_OPEN_DRAIN(HAS_OPEN_DRAIN)) i_mux (
         .sw_data   (out_q[p*PORT_W +: PORT_W]),
         .pp_mode   (pp_q[p]),
         .bus_active(bus_active),
         .bus_drive (bus_drive_en),
         .strap     (ext_strap),
         .bus_word  (bus_ad_out[p*PORT_W +: PORT_W]),
         .pad_out   (pad_out[p*PORT_W +: PORT_W]),
         .pad_oe    (pad_oe[p*PORT_W +: PORT_W])
      );
   end

   mbp_read_mux #(
      .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
   ) i_read_mux (
      .rd_en(reg_rd), .addr(reg_addr), .out_q(out_q), .pins(pad_in), .rdata(reg_rdata)
   );

   assign bus_rd_data = pad_in;
endmodule

// File: rtl/muxbus_port_ctrl_chk.sv
module muxbus_port_ctrl_chk #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int OUT_BASE  = 'h1FFC,
   localparam int BUS_W    = PORT_W * NUM_PORTS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic [PORT_W-1:0] reg_rdata,
   input logic              ext_strap,
   input logic              bus_active,
   input logic              bus_drive_en,
   input logic [BUS_W-1:0]  bus_ad_out,
   input logic [BUS_W-1:0]  bus_rd_data,
   input logic [BUS_W-1:0]  pad_in,
   input logic [BUS_W-1:0]  pad_out,
   input logic [BUS_W-1:0]  pad_oe
);
   logic in_map;
   assign in_map = (int'(reg_addr) >= OUT_BASE) && (int'(reg_addr) < OUT_BASE + 2 * NUM_PORTS);

   // R4
   bus_send_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_active && bus_drive_en) |-> (pad_oe == '1 && pad_out == bus_ad_out));

   // R5
   bus_recv_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_active && !bus_drive_en) |-> (pad_oe == '0 && bus_rd_data == pad_in));

   // R8
   strap_blocks_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_strap && !(bus_active && bus_drive_en)) |-> (pad_oe == '0));

   // R12
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !in_map) |-> (reg_rdata == '0));

   // R3
   pin_read_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && int'(reg_addr) == OUT_BASE + NUM_PORTS) |-> (reg_rdata == pad_in[PORT_W-1:0]));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      // R10
      sw_drive_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_active && !ext_strap) |->
            (pad_oe[p*PORT_W +: PORT_W] == '1 || pad_out[p*PORT_W +: PORT_W] == '0));
   end
endmodule

bind muxbus_port_ctrl muxbus_port_ctrl_chk #(
   .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
   .ext_strap(ext_strap), .bus_active(bus_active), .bus_drive_en(bus_drive_en),
   .bus_ad_out(bus_ad_out), .bus_rd_data(bus_rd_data), .pad_in(pad_in),
   .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_muxbus_port_ctrl.sv
module test_muxbus_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [1:0]  drv_pp_req = 2'b00;
   logic        ext_strap = 1'b0;
   logic        bus_active = 1'b0;
   logic        bus_drive_en = 1'b0;
   logic [15:0] bus_ad_out = '0;
   logic [15:0] bus_rd_data;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   muxbus_port_ctrl i_muxbus_port_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_pp_req(drv_pp_req),
      .ext_strap(ext_strap), .bus_active(bus_active), .bus_drive_en(bus_drive_en),
      .bus_ad_out(bus_ad_out), .bus_rd_data(bus_rd_data), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      drv_pp_req = m;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      #1 chk("R1 oe after reset", pad_oe, 16'h0000);
      rd_reg(16'h1FFC, d); chk("R1 low reg reset", d, 8'hFF);
      rd_reg(16'h1FFD, d); chk("R1 high reg reset", d, 8'hFF);
   endtask

   task automatic t_write_od;
      logic [7:0] d;
      wr_reg(16'h1FFC, 8'hA5);
      wr_reg(16'h1FFD, 8'h3C);
      rd_reg(16'h1FFC, d); chk("R2 low readback", d, 8'hA5);
      rd_reg(16'h1FFD, d); chk("R2 high readback", d, 8'h3C);
      chk("R10 od oe", pad_oe, 16'hC35A);
      chk("R10 od out", pad_out, 16'h0000);
   endtask

   task automatic t_modes;
      set_mode(2'b11);
      chk("R9 pp oe", pad_oe, 16'hFFFF);
      chk("R9 pp out", pad_out, 16'h3CA5);
      set_mode(2'b01);
      chk("R11 mixed oe", pad_oe, 16'hC3FF);
      chk("R11 mixed out", pad_out, 16'h00A5);
      set_mode(2'b10);
      chk("R11 mixed oe swap", pad_oe, 16'hFF5A);
      chk("R11 mixed out swap", pad_out, 16'h3C00);
   endtask

   task automatic t_pin_read;
      logic [7:0] d;
      pad_in = 16'h5AC3;
      rd_reg(16'h1FFE, d); chk("R3 low pin read", d, 8'hC3);
      rd_reg(16'h1FFF, d); chk("R3 high pin read", d, 8'h5A);
   endtask

   task automatic t_bus_cycle;
      logic [7:0] d;
      set_mode(2'b11);
      @(negedge clk);
      bus_active = 1'b1; bus_drive_en = 1'b1; bus_ad_out = 16'h1234;
      #1 chk("R4 send oe", pad_oe, 16'hFFFF);
      chk("R4 send out", pad_out, 16'h1234);
      @(negedge clk);
      bus_drive_en = 1'b0; pad_in = 16'h9E17;
      #1 chk("R5 recv oe", pad_oe, 16'h0000);
      chk("R5 recv data", bus_rd_data, 16'h9E17);
      rd_reg(16'h1FFE, d); chk("R3 pin read in bus cycle", d, 8'h17);
      wr_reg(16'h1FFC, 8'h77);
      #1 chk("R7 write hidden in bus cycle", pad_oe, 16'h0000);
      rd_reg(16'h1FFC, d); chk("R7 write stored in bus cycle", d, 8'h77);
      @(negedge clk);
      bus_active = 1'b0;
      @(negedge clk);
      chk("R6 restore oe", pad_oe, 16'hFFFF);
      chk("R6 R7 restore out", pad_out, 16'h3C77);
   endtask

   task automatic t_strap;
      @(negedge clk);
      ext_strap = 1'b1;
      #1 chk("R8 strap idle oe", pad_oe, 16'h0000);
      wr_reg(16'h1FFD, 8'h00);
      #1 chk("R8 strap write hidden", pad_oe, 16'h0000);
      @(negedge clk);
      bus_active = 1'b1; bus_drive_en = 1'b1; bus_ad_out = 16'hBEEF;
      #1 chk("R8 strap bus send", pad_out, 16'hBEEF);
      @(negedge clk);
      bus_active = 1'b0; bus_drive_en = 1'b0; ext_strap = 1'b0;
      #1 chk("R8 strap removed out", pad_out, 16'h0077);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      wr_reg(16'h1FFB, 8'h11);
      wr_reg(16'h2000, 8'h22);
      wr_reg(16'h1FFE, 8'h33);
      wr_reg(16'h0FFC, 8'h44);
      rd_reg(16'h1FFC, d); chk("R12 low reg untouched", d, 8'h77);
      rd_reg(16'h1FFD, d); chk("R12 high reg untouched", d, 8'h00);
      chk("R12 pins untouched", pad_out, 16'h0077);
      rd_reg(16'h1FFB, d); chk("R12 read below map", d, 8'h00);
      rd_reg(16'h2000, d); chk("R12 read above map", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_od();
      t_modes();
      t_pin_read();
      t_bus_cycle();
      t_strap();
      t_unmapped();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule